// File: doc/BRIEF.md
# Minute Pulse BCD Pre-Divider

This block counts down in two-digit BCD from a programmable preset, one step per slow tick, and so turns a 2 Hz tick into one pulse per minute. It runs on a fast system clock. The slow time base arrives as a strobe on `tick` that is high for one system clock cycle. Each strobe moves the count down by one. The active-low `zero_n` output goes low while the count is zero.

The tens nibble of the preset may be larger than 9. A preset of `0xB9` therefore means 119, and with it one pair of digits divides by 120. In normal use `zero_n` is wired back to `sync_load_n`. The tick after the count reaches zero then reloads the preset instead of wrapping the count to 99, so `zero_n` stays low for one tick period in every 120 ticks.

A separate level input, `async_load`, may come from any clock domain. It passes through a synchronizer and then holds the count at the preset for as long as it stays high. This lets the minute boundary be lined up with an outside event. The count is brought out so that it can be observed.

Top module: `bcd_minute_prescaler`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count is loaded from `preset`. After release, `count` equals `preset` until the first tick.
- R2: `count[3:0]` is the units digit and `count[7:4]` is the tens digit. A counting tick lowers a nonzero units digit by one and leaves tens unchanged. A units digit of 0 becomes 9 and the tens digit is lowered by one.
- R3: A tens digit above 9 (values 10 to 15) is lowered in plain binary when a borrow reaches it. A preset of `0xB9` therefore takes 119 counting ticks to reach `0x00`. The units nibble of the preset is limited to 0 to 9.
- R4: `zero_n` is 0 exactly when `count` is `0x00`, and it is 1 otherwise.
- R5: A tick that arrives while `sync_load_n` is 0 loads `preset` into the count and does not decrement.
- R6: A tick that arrives while the count is `0x00` and `sync_load_n` is 1 wraps the count to `0x99`.
- R7: With `zero_n` tied to `sync_load_n` and a preset of `0xB9`, `zero_n` falls once every 120 ticks. Each time it stays low from one tick to the next.
- R8: `async_load` passes through a two-flop synchronizer. A high level driven before rising edge k loads `preset` at edge k+2. The count keeps following `preset` while the synchronized level stays high, and ticks have no effect during that time.
- R9: With no tick and no synchronized load, `count` holds its value at every clock edge. A change on `preset` alone does not alter `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the preset |
| tick | input | 1 | One-cycle strobe per slow time-base period |
| preset | input | 8 | Reload value: tens nibble high (0 to 15), units nibble low (0 to 9) |
| sync_load_n | input | 1 | Active-low reload on the next tick; normally tied to `zero_n` |
| async_load | input | 1 | Level from any domain; holds the count at the preset |
| zero_n | output | 1 | Low while the count is zero |
| count | output | 8 | Present count, two BCD nibbles |

## Verification
A wrong digit shows on `count` at the first edge after it arises. If the units nibble borrows at the wrong moment, the tens nibble is wrong on the next edge. If the tens nibble borrows wrongly, the time to reach zero changes. That fault only appears at `zero_n` up to 120 ticks later, as a minute period of the wrong length, so the bench tracks the period as well as every cycle's value. A fault in the synchronizer shifts the load by whole cycles, and it is caught in the cycles just after `async_load` rises or falls.

// File: rtl/bcd_minute_prescaler.sv
module bcd_minute_prescaler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] preset,
  input  logic       sync_load_n,
  input  logic       async_load,
  output logic       zero_n,
  output logic [7:0] count
);
  localparam int DW = 4;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ld_s;
  logic [DW-1:0]          tens_q, units_q;
  logic [DW-1:0]          tens_nx, units_nx;
  logic                   borrow;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], async_load};
  end

  assign ld_s     = sync_q[SYNC_STAGES-1];
  assign borrow   = (units_q == '0);
  assign units_nx = borrow ? DW'(9) : units_q - DW'(1);
  assign tens_nx  = !borrow ? tens_q :
                    (tens_q == '0) ? DW'(9) : tens_q - DW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || ld_s || (tick && !sync_load_n)) begin
      tens_q  <= preset[2*DW-1:DW];
      units_q <= preset[DW-1:0];
    end else if (tick) begin
      tens_q  <= tens_nx;
      units_q <= units_nx;
    end
  end

  assign count  = {tens_q, units_q};
  assign zero_n = |count;
endmodule

module bcd_minute_prescaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       ld_s,
  input logic       sync_load_n,
  input logic [7:0] preset,
  input logic [7:0] count
);
  logic step;
  assign step = tick && !ld_s && sync_load_n;

  AST_LOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_s |=> count == $past(preset)); // R8

  AST_FEEDBACK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_s && !sync_load_n) |=> count == $past(preset)); // R5

  AST_UNITS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count[3:0] != 4'd0) |=>
      (count[3:0] == $past(count[3:0]) - 4'd1) && (count[7:4] == $past(count[7:4]))); // R2

  AST_UNITS_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count[3:0] == 4'd0 && count[7:4] != 4'd0) |=> count[3:0] == 4'd9); // R2

  AST_TENS_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count[3:0] == 4'd0 && count[7:4] > 4'd9) |=>
      count[7:4] == $past(count[7:4]) - 4'd1); // R3

  AST_WRAP_99: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count == 8'h00) |=> count == 8'h99); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_s) |=> $stable(count)); // R9
endmodule

bind bcd_minute_prescaler bcd_minute_prescaler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ld_s(ld_s),
  .sync_load_n(sync_load_n), .preset(preset), .count(count)
);

// File: tb/bcd_minute_prescaler_tb.sv
`timescale 1ns/1ps
module bcd_minute_prescaler_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] preset = 8'hB9;
  logic       async_load = 1'b0;
  logic       fb = 1'b1;
  logic       force_sl = 1'b1;
  logic       sync_load_n;
  logic       zero_n;
  logic [7:0] count;

  int total = 0;
  int bad = 0;
  int v = 0;
  bit q1 = 0, q2 = 0;
  string req = "R1";

  bit track = 0, seen = 0, prev_zn = 1;
  int ticks_since = 0, low_run = 0;

  always #2.5 clk = ~clk;

  assign sync_load_n = fb ? zero_n : force_sl;

  bcd_minute_prescaler u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .preset(preset),
    .sync_load_n(sync_load_n), .async_load(async_load),
    .zero_n(zero_n), .count(count)
  );

  function automatic logic [7:0] enc(int x);
    return 8'(((x / 10) << 4) | (x % 10));
  endfunction

  task automatic check_now();
    total++;
    if (count !== enc(v)) begin
      bad++;
      $display("FAIL %s count actual=%h expected=%h", req, count, enc(v));
    end
    total++;
    if (zero_n !== (v != 0)) begin
      bad++;
      $display("FAIL R4 zero_n actual=%b expected=%b", zero_n, (v != 0));
    end
    if (track) begin
      if (prev_zn && !zero_n) begin
        if (seen) begin
          total++;
          if (ticks_since != 120) begin
            bad++;
            $display("FAIL R7 ticks between minute pulses actual=%0d expected=120", ticks_since);
          end
        end
        seen = 1; ticks_since = 0; low_run = 0;
      end
      if (!zero_n) low_run++;
      if (!prev_zn && zero_n && seen) begin
        total++;
        if (low_run != 4) begin
          bad++;
          $display("FAIL R7 low width actual=%0d expected=4 cycles", low_run);
        end
      end
    end
    prev_zn = zero_n;
  endtask

  task automatic model_step(bit t);
    int pv;
    bit sl;
    pv = int'(preset[7:4]) * 10 + int'(preset[3:0]);
    if (!rst_n) begin
      v = pv; q1 = 0; q2 = 0;
    end else begin
      if (q2) v = pv;
      else if (t) begin
        sl = fb ? (v != 0) : force_sl;
        if (!sl) v = pv;
        else if (v == 0) v = 99;
        else v = v - 1;
      end
      q2 = q1; q1 = async_load;
    end
  endtask

  task automatic cyc(bit t);
    check_now();
    tick = t;
    if (t && track) ticks_since++;
    model_step(t);
    @(negedge clk);
  endtask

  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1); cyc(1'b0); cyc(1'b0); cyc(1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    model_step(1'b0);
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc(1'b0);
    rst_n = 1'b1;
    req = "R1";
    cyc(1'b0);
    total++;
    if (count !== 8'hB9) begin
      bad++;
      $display("FAIL R1 reset load actual=%h expected=b9", count);
    end

    req = "R2 R3 R7";
    track = 1;
    run_ticks(250);
    track = 0;

    req = "R9";
    preset = 8'h25;
    for (int i = 0; i < 20; i++) cyc(1'b0);
    total++;
    if (count === 8'h25) begin
      bad++;
      $display("FAIL R9 preset leaked actual=%h expected=%h", count, enc(v));
    end

    req = "R8";
    async_load = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b1);
    run_ticks(5);
    total++;
    if (count !== 8'h25) begin
      bad++;
      $display("FAIL R8 held load actual=%h expected=25", count);
    end
    async_load = 1'b0;
    run_ticks(4);

    req = "R6 R2";
    fb = 1'b0; force_sl = 1'b1;
    preset = 8'h03;
    async_load = 1'b1; cyc(1'b0); async_load = 1'b0;
    for (int i = 0; i < 3; i++) cyc(1'b0);
    run_ticks(4);
    total++;
    if (count !== 8'h99) begin
      bad++;
      $display("FAIL R6 wrap actual=%h expected=99", count);
    end
    run_ticks(12);

    req = "R5";
    preset = 8'h47;
    force_sl = 1'b0;
    cyc(1'b1);
    force_sl = 1'b1;
    cyc(1'b0);
    total++;
    if (count !== 8'h47) begin
      bad++;
      $display("FAIL R5 reload actual=%h expected=47", count);
    end
    run_ticks(10);

    req = "R3";
    preset = 8'hF0;
    force_sl = 1'b0; cyc(1'b1); force_sl = 1'b1;
    run_ticks(3);
    total++;
    if (count !== 8'hE7) begin
      bad++;
      $display("FAIL R3 tens binary step actual=%h expected=e7", count);
    end
    cyc(1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule